// File: doc/BRIEF.md
# Center-Hysteresis Threshold Comparator Bank

The block holds a bank of digital comparators with hysteresis, one for each input channel. Every channel takes an 8-bit voltage code in whole-volt units and keeps one registered sense bit. The sense bit rises once the code reaches an upper trip point. It falls once the code reaches a lower trip point. Between the two trip points the sense bit keeps its value.

The trip points are not supplied directly. Two 16-bit threshold words are supplied: one for ground-open sensing and one for supply-open sensing. Each word packs a hysteresis width and a center value, and the center is the sum of the two trip points. A per-bank mode bit chooses which word applies to the channels of that bank.

A hysteresis value with its lowest bit set is illegal. When it appears in either word, the block enters a locked state. In that state all sense bits freeze, and only a reset brings the block back.

Top module: `thr_cmp_bank`

## Requirements
- R1: A synchronous active-high reset `rst`, sampled at a rising clock edge, leaves every `sense` bit at 0 and `locked` at 0 after that edge.
- R2: Each threshold word carries the hysteresis H in bits 15:8 and the center C in bits 7:0. The rising point is floor((C+H)/2), with the sum taken without overflow. The falling point is floor((C-H)/2) when C >= H, and 0 otherwise.
- R3: When the block is not locked and neither word has an odd H, a channel whose code is at or above its rising point shows `sense` = 1 after the next edge. This rule wins over R4 when both conditions hold.
- R4: Under the same conditions, a channel whose code is below its rising point and at or below its falling point shows `sense` = 0 after the next edge.
- R5: A channel whose code lies strictly between its falling and rising points keeps its `sense` value.
- R6: Channel i belongs to bank floor(i/BANK_SIZE). Bit b of `mode_sel` selects the word for bank b: 0 selects `gnd_word` and 1 selects `sup_word`.
- R7: When bit 8 of `gnd_word` or of `sup_word` is 1 at an edge, `locked` reads 1 after that edge. In that same edge no `sense` bit changes.
- R8: While `locked` is 1, all `sense` bits hold their values and `locked` stays at 1 until a reset.
- R9: The word 0x0206 gives a falling point of 2 and a rising point of 4 and does not lock the block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vin_codes | input | NUM_CH*8 | Voltage codes; channel i is in bits 8i+7:8i |
| mode_sel | input | NUM_CH/BANK_SIZE | Per-bank word select (0 ground-open, 1 supply-open) |
| gnd_word | input | 16 | Ground-open threshold word {H, C} |
| sup_word | input | 16 | Supply-open threshold word {H, C} |
| sense | output | NUM_CH | Registered per-channel sense bits |
| locked | output | 1 | Illegal-hysteresis lock flag |

## Verification
Two functions can meet in one edge: a code crossing a trip point, and an odd hysteresis arriving in one of the threshold words. When they meet, the lock must win, and the crossing must leave no trace in `sense`. The bench first puts every channel into a known state. It then applies a crossing code to all channels and, in the same cycle, makes the hysteresis of only the supply-open word odd. After that edge it expects the old `sense` value and `locked` = 1. It then expects that value to survive further crossings until a reset arrives.

// File: rtl/thr_pkg.sv
package thr_pkg;
  localparam int unsigned FIELD_W = 8;
  localparam int unsigned WORD_W  = 2 * FIELD_W;
  localparam int unsigned NUM_WORDS = 2;

  typedef logic [FIELD_W-1:0] code_t;
  typedef logic [WORD_W-1:0]  word_t;

  typedef struct packed {
    code_t fall;
    code_t rise;
    logic  odd;
  } trip_t;
endpackage

// File: rtl/thr_decode.sv
module thr_decode
  import thr_pkg::*;
(
  input  word_t word_in,
  output trip_t trip_out
);
  code_t hyst;
  code_t ctr;

  always_comb begin
    hyst = word_in[WORD_W-1:FIELD_W];
    ctr  = word_in[FIELD_W-1:0];
    trip_out.rise = FIELD_W'(({1'b0, ctr} + {1'b0, hyst}) >> 1);
    if (ctr >= hyst) trip_out.fall = (ctr - hyst) >> 1;
    else             trip_out.fall = '0;
    trip_out.odd = hyst[0];
  end
endmodule

// File: rtl/thr_channel.sv
module thr_channel
  import thr_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  upd_en,
  input  code_t code,
  input  code_t fall,
  input  code_t rise,
  output logic  sense_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      sense_q <= 1'b0;
    end else if (upd_en) begin
      if (code >= rise)      sense_q <= 1'b1;
      else if (code <= fall) sense_q <= 1'b0;
    end
  end
endmodule

// File: rtl/thr_lock_ctrl.sv
module thr_lock_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic odd_in,
  output logic upd_en,
  output logic locked_q
);
  always_ff @(posedge clk) begin
    if (rst)         locked_q <= 1'b0;
    else if (odd_in) locked_q <= 1'b1;
  end

  assign upd_en = !locked_q && !odd_in;
endmodule

// File: rtl/thr_cmp_bank.sv
module thr_cmp_bank
  import thr_pkg::*;
#(
  parameter int unsigned NUM_CH    = 32,
  parameter int unsigned BANK_SIZE = 8
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic [NUM_CH*FIELD_W-1:0]         vin_codes,
  input  logic [(NUM_CH/BANK_SIZE)-1:0]     mode_sel,
  input  logic [WORD_W-1:0]                 gnd_word,
  input  logic [WORD_W-1:0]                 sup_word,
  output logic [NUM_CH-1:0]                 sense,
  output logic                              locked
);
  localparam int unsigned NUM_BANKS = NUM_CH / BANK_SIZE;

  word_t words [NUM_WORDS];
  trip_t trips [NUM_WORDS];
  logic [NUM_WORDS-1:0] odd_vec;
  logic odd_any;
  logic upd_en;

  logic [NUM_CH-1:0][FIELD_W-1:0] ch_code;
  logic [NUM_CH-1:0][FIELD_W-1:0] ch_fall;
  logic [NUM_CH-1:0][FIELD_W-1:0] ch_rise;

  assign words[0] = gnd_word;
  assign words[1] = sup_word;

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_dec
    thr_decode u_dec (
      .word_in (words[w]),
      .trip_out(trips[w])
    );
    assign odd_vec[w] = trips[w].odd;
  end

  assign odd_any = |odd_vec;

  thr_lock_ctrl u_lock (
    .clk     (clk),
    .rst     (rst),
    .odd_in  (odd_any),
    .upd_en  (upd_en),
    .locked_q(locked)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    localparam int unsigned BANK = i / BANK_SIZE;
    assign ch_code[i] = vin_codes[i*FIELD_W +: FIELD_W];
    assign ch_fall[i] = mode_sel[BANK] ? trips[1].fall : trips[0].fall;
    assign ch_rise[i] = mode_sel[BANK] ? trips[1].rise : trips[0].rise;

    thr_channel u_ch (
      .clk    (clk),
      .rst    (rst),
      .upd_en (upd_en),
      .code   (ch_code[i]),
      .fall   (ch_fall[i]),
      .rise   (ch_rise[i]),
      .sense_q(sense[i])
    );
  end

  if (NUM_BANKS * BANK_SIZE != NUM_CH) begin : g_bad_cfg
    initial $error("NUM_CH must be a multiple of BANK_SIZE");
  end
endmodule

// File: rtl/thr_cmp_bank_chk.sv
module thr_cmp_bank_chk
  import thr_pkg::*;
#(
  parameter int unsigned NUM_CH = 32
) (
  input logic                          clk,
  input logic                          rst,
  input logic                          odd_any,
  input logic                          locked,
  input logic [NUM_CH-1:0]             sense,
  input logic [NUM_CH-1:0][FIELD_W-1:0] ch_code,
  input logic [NUM_CH-1:0][FIELD_W-1:0] ch_fall,
  input logic [NUM_CH-1:0][FIELD_W-1:0] ch_rise
);
  assert_reset_R1: assert property (@(posedge clk)
    rst |=> (sense == '0 && !locked));

  assert_odd_locks_R7: assert property (@(posedge clk) disable iff (rst)
    odd_any |=> (locked && $stable(sense)));

  assert_lock_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    locked |=> locked);

  assert_freeze_R8: assert property (@(posedge clk) disable iff (rst)
    locked |=> $stable(sense));

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch_chk
    assert_set_R3: assert property (@(posedge clk) disable iff (rst)
      (!locked && !odd_any && ch_code[i] >= ch_rise[i]) |=> sense[i]);

    assert_clear_R4: assert property (@(posedge clk) disable iff (rst)
      (!locked && !odd_any && ch_code[i] < ch_rise[i] && ch_code[i] <= ch_fall[i])
        |=> !sense[i]);

    assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
      (ch_code[i] < ch_rise[i] && ch_code[i] > ch_fall[i]) |=> $stable(sense[i]));
  end
endmodule

bind thr_cmp_bank thr_cmp_bank_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .odd_any(odd_any),
  .locked (locked),
  .sense  (sense),
  .ch_code(ch_code),
  .ch_fall(ch_fall),
  .ch_rise(ch_rise)
);

// File: tb/thr_cmp_bank_bench.sv
module thr_cmp_bank_bench;
  localparam int NCH = 32;
  localparam int BSZ = 8;
  localparam int NBK = NCH / BSZ;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NCH*8-1:0] vin_codes = '0;
  logic [NBK-1:0] mode_sel = '0;
  logic [15:0] gnd_word = 16'h0206;
  logic [15:0] sup_word = 16'h0206;
  logic [NCH-1:0] sense;
  logic locked;

  logic [NCH-1:0] exp_sense = '0;
  logic exp_lock = 1'b0;
  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  thr_cmp_bank #(.NUM_CH(NCH), .BANK_SIZE(BSZ)) u_thr_cmp_bank (
    .clk(clk), .rst(rst), .vin_codes(vin_codes), .mode_sel(mode_sel),
    .gnd_word(gnd_word), .sup_word(sup_word), .sense(sense), .locked(locked)
  );

  function automatic int f_rise(logic [15:0] w);
    return (int'(w[7:0]) + int'(w[15:8])) / 2;
  endfunction

  function automatic int f_fall(logic [15:0] w);
    if (int'(w[7:0]) >= int'(w[15:8])) return (int'(w[7:0]) - int'(w[15:8])) / 2;
    return 0;
  endfunction

  task automatic model_step();
    bit odd;
    odd = gnd_word[8] | sup_word[8];
    if (rst) begin
      exp_sense = '0;
      exp_lock = 1'b0;
    end else begin
      if (!exp_lock && !odd) begin
        for (int i = 0; i < NCH; i++) begin
          logic [15:0] w;
          int c;
          w = mode_sel[i/BSZ] ? sup_word : gnd_word;
          c = int'(vin_codes[i*8 +: 8]);
          if (c >= f_rise(w)) exp_sense[i] = 1'b1;
          else if (c <= f_fall(w)) exp_sense[i] = 1'b0;
        end
      end
      if (odd) exp_lock = 1'b1;
    end
  endtask

  task automatic cycle(string tag);
    @(posedge clk);
    model_step();
    #1;
    n_checks++;
    if (sense !== exp_sense || locked !== exp_lock) begin
      n_fail++;
      $display("FAIL %s: sense=%h locked=%b expected sense=%h locked=%b",
               tag, sense, locked, exp_sense, exp_lock);
    end
  endtask

  task automatic set_all(int code);
    for (int i = 0; i < NCH; i++) vin_codes[i*8 +: 8] = 8'(code);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rst = 1'b1;
    cycle("R1 reset");
    cycle("R1 reset");
    @(negedge clk); rst = 1'b0; set_all(0);
    cycle("R9 legal default word");
    @(negedge clk); set_all(4);
    cycle("R3 set at rising point");
    @(negedge clk); set_all(3);
    cycle("R5 hold high");
    @(negedge clk); set_all(2);
    cycle("R4 clear at falling point");
    @(negedge clk); set_all(3);
    cycle("R5 hold low");

    // R6: supply word C=20 H=4 -> fall 8, rise 12
    @(negedge clk); sup_word = 16'h0414; mode_sel = 4'b1010; set_all(5);
    cycle("R6 bank select low code");
    @(negedge clk); set_all(12);
    cycle("R6 bank select set");
    @(negedge clk); set_all(6);
    cycle("R6 bank select mixed");

    // R2: H > C clamps fall to 0; H = 0 makes rise win
    @(negedge clk); mode_sel = '0; gnd_word = 16'h0A04; set_all(7);
    cycle("R2 clamp rise 7");
    @(negedge clk); set_all(0);
    cycle("R2 clamp fall 0");
    @(negedge clk); gnd_word = 16'h0008; set_all(4);
    cycle("R3 rise priority with zero hysteresis");
    @(negedge clk); set_all(3);
    cycle("R4 zero hysteresis clear");

    // Random main function
    for (int k = 0; k < 400; k++) begin
      @(negedge clk);
      if (k % 16 == 0) begin
        gnd_word = {8'(($urandom % 11) * 2), 8'($urandom % 46)};
        sup_word = {8'(($urandom % 11) * 2), 8'($urandom % 46)};
      end
      mode_sel = NBK'($urandom);
      for (int i = 0; i < NCH; i++) vin_codes[i*8 +: 8] = 8'($urandom % 30);
      cycle("R5 random hysteresis");
    end

    // R7: crossing and odd hysteresis in the same edge
    @(negedge clk); gnd_word = 16'h0206; sup_word = 16'h0206; mode_sel = '0; set_all(0);
    cycle("R4 prepare low");
    @(negedge clk); set_all(20); sup_word = 16'h0306;
    cycle("R7 odd blocks crossing");
    @(negedge clk); sup_word = 16'h0206;
    cycle("R8 frozen after lock");
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      for (int i = 0; i < NCH; i++) vin_codes[i*8 +: 8] = 8'($urandom % 30);
      cycle("R8 frozen random");
    end
    @(negedge clk); rst = 1'b1;
    cycle("R1 reset clears lock");
    @(negedge clk); rst = 1'b0; set_all(9);
    cycle("R3 working after reset");
    finish_run();
  end
endmodule